// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Pointer Unit

This unit owns the stack pointer of a small 16-bit processor whose software stack sits in word-aligned data RAM. The stack grows toward higher addresses. The pointer always names the next free word. A push stores the word at the pointer and then advances it by two bytes. A pop first steps the pointer back by two bytes and then reads.

On top of single pushes and pops, the unit saves and restores return frames on its own. A subroutine call or an exception stores the 23-bit program counter as two words. The low word comes first and holds PC[15:0]. The second word holds PC[22:16] in its low seven bits. Its top byte is zero for a call and the low status byte for an exception. A return reads the two words back in reverse order and presents the restored program counter. For an exception return it also presents the status byte together with a write strobe. A small sequencer makes one memory access per cycle and holds a busy flag until a frame operation ends. Software may load the pointer directly, and a loaded value is always forced to an even address.

The RAM is external and has a registered read port: data for a read issued in one cycle appears on `mem_rdata_i` in the next cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x1000, busy is low, and no memory access is requested.
- R2: A software load sets the pointer to the written value with bit 0 cleared. In an idle cycle the load wins over every other request in that cycle, and none of those other requests makes a memory access.
- R3: An idle push writes the push data at the current pointer address and leaves the pointer two higher. Write and read strobes are never active together.
- R4: An idle pop reads at pointer minus two and leaves the pointer there. One cycle later the popped word appears on the pop data output with the pop valid strobe high.
- R5: A call writes PC[15:0] at the pointer. In the next cycle, with busy high, it writes {8'h00, 1'b0, PC[22:16]} at pointer plus two. The pointer ends four higher.
- R6: An exception frame is the same as a call frame except that bits 15:8 of the second word carry the status byte sampled in the request cycle.
- R7: A return reads pointer minus two and then pointer minus four on consecutive cycles and leaves the pointer four lower. In the cycle after the second read, the return valid strobe is high and the restored PC is {upper[6:0], lower[15:1], 1'b0}. When the return is flagged as an exception return, the status write strobe is high with status = upper[15:8]. Otherwise that strobe stays low and the status output is zero.
- R8: Pointer arithmetic wraps modulo 2^16: a push at 0xFFFE leaves 0x0000, and a pop at 0x0000 reads 0xFFFE.
- R9: While busy is high, all incoming push, pop, call, exception, return and load requests are ignored. They cause no memory access and no pointer change.
- R10: When several requests arrive in the same idle cycle, precedence is load, then return, then exception, then call, then pop, then push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop request |
| call_i | input | 1 | Save call frame |
| exc_i | input | 1 | Save exception frame |
| ret_i | input | 1 | Restore frame |
| ret_exc_i | input | 1 | Restore is an exception return |
| pc_i | input | 23 | Program counter to save |
| sr_lo_i | input | 8 | Low status byte to save |
| sp_we_i | input | 1 | Software pointer load |
| sp_wdata_i | input | 16 | Value for software pointer load |
| mem_rdata_i | input | 16 | RAM read data, one cycle after the read |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | RAM byte address |
| mem_wdata_o | output | 16 | RAM write data |
| mem_we_o | output | 1 | RAM write strobe |
| mem_re_o | output | 1 | RAM read strobe |
| busy_o | output | 1 | Frame operation in progress |
| pop_valid_o | output | 1 | Popped word valid |
| pop_data_o | output | 16 | Popped word |
| ret_valid_o | output | 1 | Restored PC valid |
| pc_ret_o | output | 23 | Restored program counter |
| sr_ret_o | output | 8 | Restored status byte |
| sr_ret_we_o | output | 1 | Status restore strobe |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, 16-bit words, a 23-bit program counter, an 8-bit status byte and a reset pointer of 0x1000. With these values the frame layout is a real split, with seven upper PC bits, one spare zero bit and a full status byte all in the second word. Because the pointer is 16 bits wide, a software load near 0xFFFE reaches the wrap boundary in one or two accesses, so modulo arithmetic is exercised in both directions. The odd PC values used make the forced-zero bit 0 of the restored PC visible.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME_HI,
    ST_RET_LO,
    ST_RET_END
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH,
    OP_POP,
    OP_CALL,
    OP_EXC,
    OP_RET,
    OP_LOAD
  } stack_op_e;
endpackage

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg #(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] RESET_SP = 16'h1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] STEP = AW'(2);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= RESET_SP & ALIGN_MASK;
    else if (load_i) sp_q <= load_val_i & ALIGN_MASK;
    else if (inc_i)  sp_q <= sp_q + STEP;
    else if (dec_i)  sp_q <= sp_q - STEP;
  end

  assign sp_o = sp_q;

  // R2
  sp_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sp_q[0] == 1'b0);
  // R3
  sp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> sp_q == $past(sp_q) + STEP);
  // R4
  sp_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && !inc_i) |=> sp_q == $past(sp_q) - STEP);
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import stack_ptr_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int PCW = 23,
  parameter int SRW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic           pop_i,
  input  logic           call_i,
  input  logic           exc_i,
  input  logic           ret_i,
  input  logic           ret_exc_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_i,
  input  logic           load_req_i,
  input  logic [AW-1:0]  sp_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  output logic           mem_re_o,
  output logic           sp_load_o,
  output logic           sp_inc_o,
  output logic           sp_dec_o,
  output logic           busy_o,
  output logic           pop_issue_o,
  output logic           ret_hi_cap_o,
  output logic           ret_done_o,
  output logic           ret_exc_o
);
  localparam int HIW = PCW - DW;

  seq_state_e state_q, state_d;
  stack_op_e  op;
  logic [DW-1:0] word2_q, word2_d;
  logic          exc_q;
  logic [AW-1:0] sp_m2;

  assign sp_m2 = sp_i - AW'(2);

  always_comb begin
    op = OP_NONE;
    if (state_q == ST_IDLE) begin
      if (load_req_i)  op = OP_LOAD;
      else if (ret_i)  op = OP_RET;
      else if (exc_i)  op = OP_EXC;
      else if (call_i) op = OP_CALL;
      else if (pop_i)  op = OP_POP;
      else if (push_i) op = OP_PUSH;
    end
  end

  // second frame word: status (or zero) on top, upper PC bits at the bottom
  always_comb begin
    word2_d = '0;
    word2_d[HIW-1:0] = pc_i[PCW-1:DW];
    if (op == OP_EXC) word2_d[DW-1 -: SRW] = sr_i;
  end

  always_comb begin
    mem_addr_o  = sp_i;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    sp_load_o   = 1'b0;
    sp_inc_o    = 1'b0;
    sp_dec_o    = 1'b0;
    pop_issue_o = 1'b0;
    state_d     = state_q;
    unique case (state_q)
      ST_IDLE: begin
        unique case (op)
          OP_LOAD: sp_load_o = 1'b1;
          OP_RET: begin
            mem_re_o   = 1'b1;
            mem_addr_o = sp_m2;
            sp_dec_o   = 1'b1;
            state_d    = ST_RET_LO;
          end
          OP_EXC, OP_CALL: begin
            mem_we_o    = 1'b1;
            mem_wdata_o = pc_i[DW-1:0];
            sp_inc_o    = 1'b1;
            state_d     = ST_FRAME_HI;
          end
          OP_POP: begin
            mem_re_o    = 1'b1;
            mem_addr_o  = sp_m2;
            sp_dec_o    = 1'b1;
            pop_issue_o = 1'b1;
          end
          OP_PUSH: begin
            mem_we_o    = 1'b1;
            mem_wdata_o = push_data_i;
            sp_inc_o    = 1'b1;
          end
          default: ;
        endcase
      end
      ST_FRAME_HI: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = word2_q;
        sp_inc_o    = 1'b1;
        state_d     = ST_IDLE;
      end
      ST_RET_LO: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_m2;
        sp_dec_o   = 1'b1;
        state_d    = ST_RET_END;
      end
      ST_RET_END: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word2_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (op == OP_CALL || op == OP_EXC) word2_q <= word2_d;
      if (op == OP_RET) exc_q <= ret_exc_i;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign ret_hi_cap_o = (state_q == ST_RET_LO);
  assign ret_done_o   = (state_q == ST_RET_END);
  assign ret_exc_o    = exc_q;

  // R3
  access_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  // R5
  frame_two_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CALL || op == OP_EXC) |=> (mem_we_o && busy_o));
  // R7
  ret_sequence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RET) |=> mem_re_o ##1 ret_done_o);
  // R9
  busy_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sp_load_o);
endmodule

// File: rtl/stack_ret_unpack.sv
module stack_ret_unpack #(
  parameter int DW  = 16,
  parameter int PCW = 23,
  parameter int SRW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pop_issue_i,
  input  logic           hi_cap_i,
  input  logic           done_i,
  input  logic           exc_i,
  input  logic [DW-1:0]  rdata_i,
  output logic           pop_valid_o,
  output logic [DW-1:0]  pop_data_o,
  output logic           ret_valid_o,
  output logic [PCW-1:0] pc_ret_o,
  output logic [SRW-1:0] sr_ret_o,
  output logic           sr_we_o
);
  localparam int HIW = PCW - DW;

  logic           pop_pend_q;
  logic [HIW-1:0] hi_pc_q;
  logic [SRW-1:0] hi_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_pend_q <= 1'b0;
      hi_pc_q    <= '0;
      hi_sr_q    <= '0;
    end else begin
      pop_pend_q <= pop_issue_i;
      if (hi_cap_i) begin
        hi_pc_q <= rdata_i[HIW-1:0];
        hi_sr_q <= rdata_i[DW-1 -: SRW];
      end
    end
  end

  assign pop_valid_o = pop_pend_q;
  assign pop_data_o  = pop_pend_q ? rdata_i : '0;
  assign ret_valid_o = done_i;
  assign pc_ret_o    = done_i ? {hi_pc_q, rdata_i[DW-1:1], 1'b0} : '0;
  assign sr_we_o     = done_i && exc_i;
  assign sr_ret_o    = sr_we_o ? hi_sr_q : '0;

  // R4
  pop_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_issue_i |=> pop_valid_o);
  // R7
  sr_we_in_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> ret_valid_o);
  // R7
  pc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> pc_ret_o[0] == 1'b0);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter int            PCW      = 23,
  parameter int            SRW      = 8,
  parameter logic [AW-1:0] RESET_SP = 16'h1000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic           pop_i,
  input  logic           call_i,
  input  logic           exc_i,
  input  logic           ret_i,
  input  logic           ret_exc_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_lo_i,
  input  logic           sp_we_i,
  input  logic [AW-1:0]  sp_wdata_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  sp_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  output logic           mem_re_o,
  output logic           busy_o,
  output logic           pop_valid_o,
  output logic [DW-1:0]  pop_data_o,
  output logic           ret_valid_o,
  output logic [PCW-1:0] pc_ret_o,
  output logic [SRW-1:0] sr_ret_o,
  output logic           sr_ret_we_o
);
  logic sp_load, sp_inc, sp_dec;
  logic pop_issue, ret_hi_cap, ret_done, ret_exc;
  logic [AW-1:0] sp;

  stack_ptr_reg #(.AW(AW), .RESET_SP(RESET_SP)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sp_load),
    .load_val_i (sp_wdata_i),
    .inc_i      (sp_inc),
    .dec_i      (sp_dec),
    .sp_o       (sp)
  );

  stack_frame_seq #(.AW(AW), .DW(DW), .PCW(PCW), .SRW(SRW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push_i),
    .push_data_i  (push_data_i),
    .pop_i        (pop_i),
    .call_i       (call_i),
    .exc_i        (exc_i),
    .ret_i        (ret_i),
    .ret_exc_i    (ret_exc_i),
    .pc_i         (pc_i),
    .sr_i         (sr_lo_i),
    .load_req_i   (sp_we_i),
    .sp_i         (sp),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .sp_load_o    (sp_load),
    .sp_inc_o     (sp_inc),
    .sp_dec_o     (sp_dec),
    .busy_o       (busy_o),
    .pop_issue_o  (pop_issue),
    .ret_hi_cap_o (ret_hi_cap),
    .ret_done_o   (ret_done),
    .ret_exc_o    (ret_exc)
  );

  stack_ret_unpack #(.DW(DW), .PCW(PCW), .SRW(SRW)) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_issue_i (pop_issue),
    .hi_cap_i    (ret_hi_cap),
    .done_i      (ret_done),
    .exc_i       (ret_exc),
    .rdata_i     (mem_rdata_i),
    .pop_valid_o (pop_valid_o),
    .pop_data_o  (pop_data_o),
    .ret_valid_o (ret_valid_o),
    .pc_ret_o    (pc_ret_o),
    .sr_ret_o    (sr_ret_o),
    .sr_we_o     (sr_ret_we_o)
  );

  assign sp_o = sp;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !push_i && !pop_i && !call_i && !exc_i && !ret_i) |-> !(mem_we_o || mem_re_o));
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 0, pop = 0, call = 0, exc = 0, ret = 0, ret_exc = 0, sp_we = 0;
  logic [15:0] push_data = '0, sp_wdata = '0, mem_rdata = '0;
  logic [22:0] pc = '0;
  logic [7:0]  sr = '0;
  logic [15:0] sp, mem_addr, mem_wdata, pop_data;
  logic        mem_we, mem_re, busy, pop_valid, ret_valid, sr_we;
  logic [22:0] pc_ret;
  logic [7:0]  sr_ret;

  int errors = 0;
  int checks = 0;

  stack_ptr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(push_data), .pop_i(pop),
    .call_i(call), .exc_i(exc), .ret_i(ret), .ret_exc_i(ret_exc), .pc_i(pc), .sr_lo_i(sr),
    .sp_we_i(sp_we), .sp_wdata_i(sp_wdata), .mem_rdata_i(mem_rdata), .sp_o(sp),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .busy_o(busy), .pop_valid_o(pop_valid), .pop_data_o(pop_data), .ret_valid_o(ret_valid),
    .pc_ret_o(pc_ret), .sr_ret_o(sr_ret), .sr_ret_we_o(sr_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // environment RAM, registered read
  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'hDEAD;
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
  end

  // behavioural reference state
  int          m_sp = 'h1000;
  int          m_phase = 0;
  logic [15:0] m_word2 = '0;
  bit          m_exc = 0;
  bit          m_pop_pend = 0;
  int          m_pop_addr = 0, m_hi_addr = 0, m_lo_addr = 0;
  logic [15:0] m_mem [int];

  function automatic logic [15:0] mrd(int a);
    return m_mem.exists(a) ? m_mem[a] : 16'hDEAD;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(string req, bit i_push, bit i_pop, bit i_call, bit i_exc, bit i_ret,
                      bit i_rexc, bit i_we, logic [15:0] wval, logic [15:0] pdata,
                      logic [22:0] i_pc, logic [7:0] i_sr);
    bit e_we = 0, e_re = 0, e_popv, e_retv, e_srwe, n_pop = 0;
    int e_addr = 0, nsp, nphase;
    logic [15:0] e_wd = '0, e_popd, hi, lo;
    logic [22:0] e_pc;
    logic [7:0]  e_sr;
    push = i_push; pop = i_pop; call = i_call; exc = i_exc; ret = i_ret; ret_exc = i_rexc;
    sp_we = i_we; sp_wdata = wval; push_data = pdata; pc = i_pc; sr = i_sr;
    #1;
    nsp = m_sp; nphase = m_phase;
    e_popv = m_pop_pend;
    e_popd = m_pop_pend ? mrd(m_pop_addr) : 16'h0;
    e_retv = (m_phase == 3);
    hi = mrd(m_hi_addr); lo = mrd(m_lo_addr);
    e_pc = e_retv ? {hi[6:0], lo[15:1], 1'b0} : 23'h0;
    e_srwe = e_retv && m_exc;
    e_sr = e_srwe ? hi[15:8] : 8'h0;
    case (m_phase)
      0: begin
        if (i_we) nsp = wval & 'hFFFE;
        else if (i_ret) begin
          e_re = 1; e_addr = (m_sp - 2) & 'hFFFF; m_hi_addr = e_addr; nsp = e_addr;
          nphase = 2; m_exc = i_rexc;
        end else if (i_exc || i_call) begin
          e_we = 1; e_addr = m_sp; e_wd = i_pc[15:0]; nsp = (m_sp + 2) & 'hFFFF; nphase = 1;
          m_word2 = {i_exc ? i_sr : 8'h00, 1'b0, i_pc[22:16]};
        end else if (i_pop) begin
          e_re = 1; e_addr = (m_sp - 2) & 'hFFFF; nsp = e_addr; n_pop = 1; m_pop_addr = e_addr;
        end else if (i_push) begin
          e_we = 1; e_addr = m_sp; e_wd = pdata; nsp = (m_sp + 2) & 'hFFFF;
        end
      end
      1: begin e_we = 1; e_addr = m_sp; e_wd = m_word2; nsp = (m_sp + 2) & 'hFFFF; nphase = 0; end
      2: begin e_re = 1; e_addr = (m_sp - 2) & 'hFFFF; m_lo_addr = e_addr; nsp = e_addr; nphase = 3; end
      default: nphase = 0;
    endcase
    chk(req, "sp", {16'h0, sp}, m_sp);
    chk(req, "busy", {31'h0, busy}, {31'h0, m_phase != 0});
    chk(req, "we", {31'h0, mem_we}, {31'h0, e_we});
    chk(req, "re", {31'h0, mem_re}, {31'h0, e_re});
    if (e_we || e_re) chk(req, "addr", {16'h0, mem_addr}, e_addr);
    if (e_we) chk(req, "wdata", {16'h0, mem_wdata}, {16'h0, e_wd});
    chk(req, "pop_valid", {31'h0, pop_valid}, {31'h0, e_popv});
    if (e_popv) chk(req, "pop_data", {16'h0, pop_data}, {16'h0, e_popd});
    chk(req, "ret_valid", {31'h0, ret_valid}, {31'h0, e_retv});
    chk(req, "sr_we", {31'h0, sr_we}, {31'h0, e_srwe});
    if (e_retv) begin
      chk(req, "pc_ret", {9'h0, pc_ret}, {9'h0, e_pc});
      chk(req, "sr_ret", {24'h0, sr_ret}, {24'h0, e_sr});
    end
    @(posedge clk);
    if (e_we) m_mem[e_addr] = e_wd;
    m_sp = nsp; m_phase = nphase; m_pop_pend = n_pop;
    @(negedge clk);
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0, 23'h0, 8'h0);
  endtask
  task automatic do_push(string req, logic [15:0] d);
    step(req, 1, 0, 0, 0, 0, 0, 0, 16'h0, d, 23'h0, 8'h0);
  endtask
  task automatic do_pop(string req);
    step(req, 0, 1, 0, 0, 0, 0, 0, 16'h0, 16'h0, 23'h0, 8'h0);
  endtask
  task automatic do_load(string req, logic [15:0] v, bit also_push, bit also_pop);
    step(req, also_push, also_pop, 0, 0, 0, 0, 1, v, 16'hBEEF, 23'h0, 8'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "sp_reset", {16'h0, sp}, 32'h1000);
    chk("R1", "busy_reset", {31'h0, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1");

    // R3 pushes then R4 pops
    do_push("R3", 16'h1111); do_push("R3", 16'h2222); do_push("R3", 16'h3333);
    do_pop("R4"); do_pop("R4"); do_pop("R4"); idle("R4");

    // R2 load forced even, wins over push / pop
    do_load("R2", 16'h2345, 1, 0);
    do_load("R2", 16'h3001, 0, 1);
    do_push("R2", 16'hA5A5); idle("R2");

    // R5 call frame, R7 plain return
    step("R5", 0, 0, 1, 0, 0, 0, 0, 16'h0, 16'h0, 23'h5A_1235, 8'h77);
    idle("R5"); idle("R5");
    step("R7", 0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0, 23'h0, 8'h0);
    idle("R7"); idle("R7"); idle("R7");

    // R6 exception frame; R9 requests during busy ignored
    step("R6", 0, 0, 0, 1, 0, 0, 0, 16'h0, 16'h0, 23'h7F_FFFF, 8'hA5);
    step("R9", 1, 1, 1, 1, 1, 0, 1, 16'h0100, 16'hCAFE, 23'h1, 8'h1);
    idle("R6");
    step("R7", 0, 0, 0, 0, 1, 1, 0, 16'h0, 16'h0, 23'h0, 8'h0);
    step("R9", 1, 0, 0, 0, 0, 0, 1, 16'h0200, 16'hCAFE, 23'h0, 8'h0);
    step("R9", 0, 1, 1, 0, 0, 0, 0, 16'h0, 16'h0, 23'h0, 8'h0);
    idle("R7");

    // R8 wrap both ways
    do_load("R8", 16'hFFFE, 0, 0);
    do_push("R8", 16'h5151);
    do_push("R8", 16'h6262);
    do_pop("R8"); do_pop("R8"); idle("R8");
    do_load("R8", 16'h0000, 0, 0);
    do_pop("R8"); idle("R8");

    // R10 precedence
    do_load("R10", 16'h4000, 0, 0);
    do_push("R10", 16'h0A0A);
    step("R10", 1, 1, 0, 0, 0, 0, 0, 16'h0, 16'hBBBB, 23'h0, 8'h0);
    idle("R10");
    step("R10", 1, 1, 1, 1, 0, 0, 0, 16'h0, 16'hBBBB, 23'h12_3457, 8'h3C);
    idle("R10");
    step("R10", 1, 1, 1, 1, 1, 1, 0, 16'h0, 16'hBBBB, 23'h1, 8'h1);
    idle("R10"); idle("R10");
    step("R10", 1, 0, 1, 0, 0, 0, 0, 16'h0, 16'hBBBB, 23'h00_0F0F, 8'h0);
    idle("R10");
    step("R10", 0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0, 23'h0, 8'h0);
    idle("R10"); idle("R10");

    // R3 R4 mixed sequence
    for (int i = 0; i < 40; i++) begin
      if ((i * 7) % 5 < 3) do_push("R3", 16'(i * 16'h0357 + 16'h11));
      else do_pop("R4");
    end
    idle("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule